// File: doc/BRIEF.md
# Debug Event Trace Capture Buffer

This block is a circular trace store that sits beside a processing pipeline and records the 64-bit debug words that pipeline emits. Each incoming event carries a 4-bit class number. An event is recorded only when capture is running and the mask bit for its class is set. A hardware write pointer walks a 128-entry store and wraps back to zero. Software watches and steers the store through two registers: a control/status word and a 64-bit data window.

In the single-word modes, each accepted event stores one word. In the paired modes, an accepted event stores its first word at once and a second word on the following cycle. A status flag tells software whether the most recent pair was finished. In the alternate paired mode, the second word is taken from one of two sources, chosen by a bit inside the first word.

To read the store, software clears the enable bit. It then steps the read pointer across the store, reading the data window at each step. Setting the enable bit again resumes capture at the point where it stopped. The upper half of the control word has two meanings: on a write it loads the event mask, and on a read it returns pointer and flag status.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the control/status word reads as zero: capture disabled, mode 0, read pointer 0, write pointer 0, pair flag 0.
- R2: The control/status word (register offset 0) reads back as follows: bits 6:0 hold the read pointer, bit 12 the enable, bits 15:14 the mode, bits 22:16 the write pointer and bit 23 the pair flag. All other bits read as zero.
- R3: A write to offset 0 loads the enable from bit 12, the mode from bits 15:14, the read pointer from bits 6:0 and the 16-bit event mask from bits 31:16. The mask is never returned on a read.
- R4: In modes 0 and 1, when an event is accepted, its first word is stored at the write pointer and the write pointer advances by one on the same clock edge.
- R5: An event is accepted only when the valid input is high and the mask bit indexed by its class is set. Any other event leaves the write pointer and the store unchanged.
- R6: The write pointer wraps from 127 to 0, and later events overwrite the oldest entries.
- R7: While the enable is clear, nothing is stored and the write pointer holds. When the enable is set again, capture continues from the same write pointer.
- R8: A read of offset 4 returns the stored word at the read pointer. Writes to offset 4 change nothing.
- R9: In modes 2 and 3, an accepted event stores its first word and clears the pair flag. On the next enabled cycle the second word is stored at the following slot and the flag is set. An event that arrives while a second word is still pending is dropped.
- R10: In mode 2 the second word always comes from the primary second-word input. In mode 3 it comes from the alternate input when bit 17 of the first word is 1, and from the primary input when that bit is 0.
- R11: If capture is frozen while a second word is pending, the flag stays clear and the slot at the write pointer is left unwritten. On resume, that slot receives the pending second word first.
- R12: A control write that changes the read pointer in the same cycle as an accepted event does not disturb the write pointer advance or the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_valid | input | 1 | Event present this cycle |
| evt_cls | input | 4 | Event class, indexes the event mask |
| evt_first | input | 64 | First (or only) word of the event |
| evt_second | input | 64 | Primary second word for paired modes |
| evt_second_alt | input | 64 | Alternate second word for mode 3 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset: 0 control/status, 4 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational on reg_addr |

## Verification
The bench aims at the cases where the pointers and the pair state are easy to get wrong. The first is the wrap from slot 127 to 0: a design that saturates the pointer, or wraps it one entry early, leaves the wrong words in slots 0 and 1. The second is a freeze that lands between the two words of a pair: a design that drops the pending word, or writes it while frozen, shows the flag set or the pointer moved during the freeze. The third is an event that arrives while a second word is pending: a design that accepts it moves the pointer by three instead of two. The bench also checks the mode 3 source select in both polarities, a read-pointer write in the same cycle as an event, and that the mask never shows in the status bits. A design with a shifted field or a leaked mask fails the full-word status compares.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  // register byte offsets
  localparam int unsigned CTRL_OFS     = 0;
  localparam int unsigned DATA_OFS     = 4;
  // control/status field positions (software decodes these)
  localparam int unsigned RPTR_LSB     = 0;
  localparam int unsigned EN_BIT       = 12;
  localparam int unsigned MODE_LSB     = 14;
  localparam int unsigned WPTR_LSB     = 16;
  localparam int unsigned FLAG_BIT     = 23;
  localparam int unsigned MASK_LSB     = 16;
  localparam int unsigned PTR_FIELD_W  = 7;
  // bit of the first word that picks the mode-3 second-word source
  localparam int unsigned ALT_SEL_BIT  = 17;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_SINGLE_B = 2'd1,
    MODE_PAIR     = 2'd2,
    MODE_PAIR_ALT = 2'd3
  } cap_mode_e;

  function automatic logic mode_is_pair(cap_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/tcb_rst_sync.sv
module tcb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/tcb_regs.sv
module tcb_regs
  import tcb_pkg::*;
#(
  parameter int unsigned PTR_W  = 7,
  parameter int unsigned MASK_W = 16,
  parameter int unsigned REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [PTR_W-1:0]  wptr,
  input  logic              pair_done,
  output logic              cap_en,
  output cap_mode_e         cap_mode,
  output logic [MASK_W-1:0] evt_mask,
  output logic [PTR_W-1:0]  rptr,
  output logic [31:0]       status
);
  logic              en_q, en_n;
  cap_mode_e         mode_q, mode_n;
  logic [MASK_W-1:0] mask_q, mask_n;
  logic [PTR_W-1:0]  rptr_q, rptr_n;
  logic              ctrl_hit;
  logic              unused_wbits;

  assign ctrl_hit     = reg_wr && (reg_addr == REG_AW'(CTRL_OFS));
  assign unused_wbits = ^{reg_wdata[13], reg_wdata[11:PTR_W]};

  always_comb begin
    en_n   = en_q;
    mode_n = mode_q;
    mask_n = mask_q;
    rptr_n = rptr_q;
    if (ctrl_hit) begin
      en_n   = reg_wdata[EN_BIT];
      mode_n = cap_mode_e'(reg_wdata[MODE_LSB +: 2]);
      mask_n = reg_wdata[MASK_LSB +: MASK_W];
      rptr_n = reg_wdata[RPTR_LSB +: PTR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= MODE_SINGLE;
      mask_q <= '1;
      rptr_q <= '0;
    end else if (ctrl_hit) begin
      en_q   <= en_n;
      mode_q <= mode_n;
      mask_q <= mask_n;
      rptr_q <= rptr_n;
    end
  end

  always_comb begin
    status = '0;
    status[RPTR_LSB +: PTR_FIELD_W] = PTR_FIELD_W'(rptr_q);
    status[EN_BIT]                  = en_q;
    status[MODE_LSB +: 2]           = mode_q;
    status[WPTR_LSB +: PTR_FIELD_W] = PTR_FIELD_W'(wptr);
    status[FLAG_BIT]                = pair_done;
  end

  assign cap_en   = en_q;
  assign cap_mode = mode_q;
  assign evt_mask = mask_q;
  assign rptr     = rptr_q;

  // R3: a control write loads the mask from the upper half
  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> evt_mask == $past(reg_wdata[MASK_LSB +: MASK_W]));

  // R8: writes to any other offset leave the control state alone
  assert_data_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !ctrl_hit) |=> $stable({cap_en, cap_mode, evt_mask, rptr}));
endmodule

// File: rtl/tcb_capture.sv
module tcb_capture
  import tcb_pkg::*;
#(
  parameter int unsigned PTR_W  = 7,
  parameter int unsigned WORD_W = 64,
  parameter int unsigned MASK_W = 16,
  parameter int unsigned CLS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  cap_mode_e         cap_mode,
  input  logic [MASK_W-1:0] evt_mask,
  input  logic              evt_valid,
  input  logic [CLS_W-1:0]  evt_cls,
  input  logic [WORD_W-1:0] evt_first,
  input  logic [WORD_W-1:0] evt_second,
  input  logic [WORD_W-1:0] evt_second_alt,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_waddr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [PTR_W-1:0]  wptr,
  output logic              pair_done
);
  logic [PTR_W-1:0]  wptr_q, wptr_n;
  logic              flag_q, flag_n;
  logic              pend_q, pend_n;
  logic [WORD_W-1:0] hold_q, hold_n;
  logic              hold_ld;
  logic              evt_take;

  assign evt_take = evt_valid && evt_mask[evt_cls];

  always_comb begin
    wptr_n    = wptr_q;
    flag_n    = flag_q;
    pend_n    = pend_q;
    hold_n    = hold_q;
    hold_ld   = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = evt_first;
    if (cap_en) begin
      if (pend_q) begin
        mem_we    = 1'b1;
        mem_wdata = hold_q;
        wptr_n    = wptr_q + PTR_W'(1);
        pend_n    = 1'b0;
        flag_n    = 1'b1;
      end else if (evt_take) begin
        mem_we    = 1'b1;
        mem_wdata = evt_first;
        wptr_n    = wptr_q + PTR_W'(1);
        if (mode_is_pair(cap_mode)) begin
          pend_n  = 1'b1;
          flag_n  = 1'b0;
          hold_ld = 1'b1;
          hold_n  = (cap_mode == MODE_PAIR_ALT && evt_first[ALT_SEL_BIT])
                    ? evt_second_alt : evt_second;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (cap_en) begin
      wptr_q <= wptr_n;
      flag_q <= flag_n;
      pend_q <= pend_n;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_ld) hold_q <= hold_n;
  end

  assign mem_waddr = wptr_q;
  assign wptr      = wptr_q;
  assign pair_done = flag_q;

  // R7: frozen capture keeps the write pointer still
  assert_freeze_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(wptr));

  // R6: the pointer only steps by one, modulo the depth
  assert_wptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wptr == $past(wptr)) || (wptr == $past(wptr) + PTR_W'(1)));

  // R5: unqualified events with nothing pending leave the pointer alone
  assert_unqualified_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !(evt_valid && evt_mask[evt_cls])) |=> $stable(wptr));

  // R9: the pair flag only rises when a pending second word lands
  assert_flag_after_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_done) |-> $past(pend_q));
endmodule

// File: rtl/tcb_store.sv
module tcb_store #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned WORD_W = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R4: a write lands in the addressed slot
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned WORD_W = 64,
  parameter int unsigned MASK_W = 16,
  parameter int unsigned REG_AW = 3,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CLS_W = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [CLS_W-1:0]  evt_cls,
  input  logic [WORD_W-1:0] evt_first,
  input  logic [WORD_W-1:0] evt_second,
  input  logic [WORD_W-1:0] evt_second_alt,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [WORD_W-1:0] reg_rdata
);
  logic              rst_n_i;
  logic              cap_en;
  cap_mode_e         cap_mode;
  logic [MASK_W-1:0] evt_mask;
  logic [PTR_W-1:0]  rptr, wptr;
  logic              pair_done;
  logic [31:0]       status;
  logic              mem_we;
  logic [PTR_W-1:0]  mem_waddr;
  logic [WORD_W-1:0] mem_wdata, rd_word;

  tcb_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  tcb_regs #(.PTR_W(PTR_W), .MASK_W(MASK_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .wptr(wptr), .pair_done(pair_done),
    .cap_en(cap_en), .cap_mode(cap_mode), .evt_mask(evt_mask),
    .rptr(rptr), .status(status)
  );

  tcb_capture #(.PTR_W(PTR_W), .WORD_W(WORD_W), .MASK_W(MASK_W), .CLS_W(CLS_W)) u_cap (
    .clk(clk), .rst_n(rst_n_i), .cap_en(cap_en), .cap_mode(cap_mode),
    .evt_mask(evt_mask), .evt_valid(evt_valid), .evt_cls(evt_cls),
    .evt_first(evt_first), .evt_second(evt_second),
    .evt_second_alt(evt_second_alt), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .wptr(wptr),
    .pair_done(pair_done)
  );

  tcb_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n_i), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(rptr), .rdata(rd_word)
  );

  always_comb begin
    case (reg_addr)
      REG_AW'(CTRL_OFS): reg_rdata = WORD_W'(status);
      REG_AW'(DATA_OFS): reg_rdata = rd_word;
      default:           reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/trace_capture_buf_test.sv
module trace_capture_buf_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [3:0]  evt_cls;
  logic [63:0] evt_first, evt_second, evt_second_alt;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [63:0] reg_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench-side model, built from the requirements
  logic [63:0] mdl [128];
  int          wp = 0;
  bit          flag_e = 0;
  bit          cur_en = 0;
  logic [1:0]  cur_mode = 2'd0;
  logic [15:0] cur_mask = 16'hffff;
  logic [6:0]  cur_rptr = 7'd0;

  always #2 clk = ~clk;

  trace_capture_buf uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_cls(evt_cls),
    .evt_first(evt_first), .evt_second(evt_second),
    .evt_second_alt(evt_second_alt), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(bit en, logic [1:0] md,
                                            logic [15:0] msk, logic [6:0] rp);
    return {msk, md, 1'b0, en, 5'b0, rp};
  endfunction

  function automatic logic [63:0] exp_status();
    return {32'h0, 8'h0, flag_e, 7'(wp), cur_mode, 1'b0, cur_en, 5'b0, cur_rptr};
  endfunction

  function automatic void record(logic [63:0] w);
    mdl[wp] = w;
    wp = (wp + 1) % 128;
  endfunction

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_ctrl(bit en, logic [1:0] md, logic [15:0] msk, logic [6:0] rp);
    cur_en = en; cur_mode = md; cur_mask = msk; cur_rptr = rp;
    reg_write(3'd0, ctrl_word(en, md, msk, rp));
  endtask

  task automatic reg_read(logic [2:0] a, output logic [63:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic read_slot(int idx, output logic [63:0] v);
    set_ctrl(cur_en, cur_mode, cur_mask, 7'(idx));
    reg_read(3'd4, v);
  endtask

  task automatic check_status(string req);
    logic [63:0] v;
    reg_read(3'd0, v);
    chk(req, v, exp_status());
  endtask

  task automatic check_slot(string req, int idx);
    logic [63:0] v;
    read_slot(idx, v);
    chk(req, v, mdl[idx]);
  endtask

  task automatic drive_evt(bit vld, logic [3:0] c, logic [63:0] a,
                           logic [63:0] b, logic [63:0] alt);
    evt_valid = vld; evt_cls = c; evt_first = a; evt_second = b; evt_second_alt = alt;
  endtask

  task automatic send(bit vld, logic [3:0] c, logic [63:0] a,
                      logic [63:0] b, logic [63:0] alt);
    drive_evt(vld, c, a, b, alt);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // R1 R2: reset state of the control/status word
  task automatic t_reset();
    logic [63:0] v;
    reg_read(3'd0, v);
    chk("R1 reset status", v, 64'h0);
  endtask

  // R4 R2: single-word capture in modes 0 and 1
  task automatic t_single();
    set_ctrl(1, 2'd0, 16'hffff, 7'd0);
    send(1, 4'd0,  64'h1111_0000_0000_0001, 64'h0, 64'h0); record(64'h1111_0000_0000_0001);
    send(1, 4'd5,  64'h2222_0000_0000_0002, 64'h0, 64'h0); record(64'h2222_0000_0000_0002);
    send(1, 4'd15, 64'h3333_0000_0000_0003, 64'h0, 64'h0); record(64'h3333_0000_0000_0003);
    check_status("R2 status after three events");
    for (int i = 0; i < 3; i++) check_slot("R4 single-word contents", i);
    set_ctrl(1, 2'd1, 16'hffff, 7'd0);
    send(1, 4'd7, 64'h4444_0000_0000_0004, 64'h0, 64'h0); record(64'h4444_0000_0000_0004);
    check_slot("R4 mode 1 contents", 3);
    check_status("R4 mode 1 pointer");
  endtask

  // R5 R3: mask qualification; mask never appears in status
  task automatic t_mask();
    set_ctrl(1, 2'd0, 16'h0021, 7'd0);
    send(1, 4'd1, 64'hdead_0000_0000_0001, 64'h0, 64'h0);
    check_status("R5 masked class ignored");
    send(0, 4'd0, 64'hdead_0000_0000_0002, 64'h0, 64'h0);
    check_status("R5 invalid event ignored");
    send(1, 4'd5, 64'h5555_0000_0000_0005, 64'h0, 64'h0); record(64'h5555_0000_0000_0005);
    check_status("R3 status shows pointer, not mask");
    check_slot("R5 enabled class captured", 4);
  endtask

  // R6: wrap past the top of the store
  task automatic t_wrap();
    int n;
    set_ctrl(1, 2'd0, 16'hffff, 7'd0);
    n = 130 - wp;
    for (int i = 0; i < n; i++) begin
      logic [63:0] w;
      w = 64'hA000_0000_0000_0000 | 64'(i);
      send(1, 4'(i), w, 64'h0, 64'h0);
      record(w);
    end
    check_status("R6 pointer wrapped to 2");
    check_slot("R6 slot 0 overwritten", 0);
    check_slot("R6 slot 1 overwritten", 1);
    check_slot("R6 slot 127", 127);
    check_slot("R6 slot 5", 5);
  endtask

  // R12 R8: read-pointer write alongside an event; data-offset write ignored
  task automatic t_rptr_running();
    logic [63:0] v;
    cur_rptr = 7'd9;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = ctrl_word(1, cur_mode, cur_mask, 7'd9);
    send(1, 4'd2, 64'hBEEF_0000_0000_0012, 64'h0, 64'h0);
    reg_wr = 1'b0;
    record(64'hBEEF_0000_0000_0012);
    check_status("R12 pointer advanced once with rptr write");
    check_slot("R12 captured word intact", 2);
    check_slot("R12 other slot intact", 9);
    reg_write(3'd4, 32'hFFFF_FFFF);
    check_status("R8 data-offset write changes no control");
    reg_read(3'd4, v);
    chk("R8 data-offset write changes no data", v, mdl[9]);
  endtask

  // R7: freeze and resume
  task automatic t_freeze();
    set_ctrl(0, 2'd0, 16'hffff, 7'd0);
    for (int i = 0; i < 3; i++) send(1, 4'd3, 64'hF00D_0000_0000_0000, 64'h0, 64'h0);
    check_status("R7 frozen pointer holds");
    check_slot("R7 frozen slot untouched", 2);
    check_slot("R7 frozen next slot untouched", 3);
    set_ctrl(1, 2'd0, 16'hffff, 7'd0);
    send(1, 4'd3, 64'h7777_0000_0000_0007, 64'h0, 64'h0); record(64'h7777_0000_0000_0007);
    check_status("R7 resumed from same pointer");
    check_slot("R7 resumed capture", 3);
  endtask

  // R9 R10: mode 2 pairs, drop during pending, source select
  task automatic t_pair2();
    logic [63:0] v;
    int w0;
    set_ctrl(1, 2'd2, 16'hffff, 7'd0);
    w0 = wp;
    // bit 17 set: mode 2 must still take the primary second word
    send(1, 4'd1, 64'h0000_0000_0002_00A1, 64'hB1B1_B1B1_B1B1_B1B1, 64'hC1C1_C1C1_C1C1_C1C1);
    reg_read(3'd0, v);
    chk("R9 mid-pair flag clear", v[23], 1'b0);
    chk("R9 mid-pair pointer", 64'(v[22:16]), 64'((w0 + 1) % 128));
    // arrives during the pending cycle: dropped
    send(1, 4'd1, 64'h0000_0000_0000_00A2, 64'hB2B2, 64'hC2C2);
    idle(2);
    record(64'h0000_0000_0002_00A1);
    record(64'hB1B1_B1B1_B1B1_B1B1);
    flag_e = 1;
    check_status("R9 pair complete, extra event dropped");
    check_slot("R9 first word", w0);
    check_slot("R10 mode 2 second word primary", (w0 + 1) % 128);
  endtask

  // R10: mode 3 source select on bit 17
  task automatic t_pair3();
    int w0;
    set_ctrl(1, 2'd3, 16'hffff, 7'd0);
    w0 = wp;
    send(1, 4'd4, 64'h0000_0000_0002_0031, 64'hB3, 64'hC3); idle(1);
    record(64'h0000_0000_0002_0031); record(64'hC3);
    send(1, 4'd4, 64'h0000_0000_0000_0032, 64'hB4, 64'hC4); idle(1);
    record(64'h0000_0000_0000_0032); record(64'hB4);
    check_status("R10 mode 3 two pairs");
    check_slot("R10 alt source when bit 17 set", (w0 + 1) % 128);
    check_slot("R10 primary source when bit 17 clear", (w0 + 3) % 128);
  endtask

  // R11: freeze in the middle of a pair
  task automatic t_freeze_pair();
    int w0;
    set_ctrl(1, 2'd2, 16'hffff, 7'd0);
    w0 = wp;
    cur_en = 0;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = ctrl_word(0, 2'd2, 16'hffff, cur_rptr);
    send(1, 4'd6, 64'h0000_0000_0000_00E1, 64'hE2E2_E2E2, 64'hE3);
    reg_wr = 1'b0;
    record(64'h0000_0000_0000_00E1);
    flag_e = 0;
    idle(3);
    check_status("R11 frozen mid-pair: flag clear, pointer at pending slot");
    set_ctrl(1, 2'd2, 16'hffff, cur_rptr);
    idle(1);
    record(64'hE2E2_E2E2);
    flag_e = 1;
    check_status("R11 resumed pair complete");
    check_slot("R11 pending word landed in held slot", (w0 + 1) % 128);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 32'h0;
    drive_evt(0, 4'd0, 64'h0, 64'h0, 64'h0);
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_single();
    t_mask();
    t_wrap();
    t_rptr_running();
    t_freeze();
    t_pair2();
    t_pair3();
    t_freeze_pair();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule